// File: doc/BRIEF.md
# Packet Receive Buffer with Clear-to-Send Throttle

This block sits behind a serial receiver on a device that talks to a faster host. Bytes arrive one per strobe, with a marker on the last byte of each packet. The block groups them into packets of 1 to 16 bytes and keeps up to four completed packets, 64 bytes of storage in all. A consumer that works at a fixed pace takes one whole packet per processing interval. It reads the head packet's length and bytes by index, then releases that entry.

The clear-to-send output drops as soon as three packets are complete. This leaves a whole free entry, so a host that is slow to notice the throttle can still land a partial or full packet without loss. The output rises again once two or fewer completed packets remain. A byte that arrives while all four entries are complete is discarded, and this sets a sticky overflow flag.

Top module: `pkt_fifo_cts`

## Requirements
- R1: For the head packet, `rd_data` shows the byte at index `rd_addr`, with index 0 being the first byte received. Packets leave in the order they completed.
- R2: A byte accepted with `in_last` high closes the current packet. The stored length equals the number of bytes accepted for it, from 1 to 16.
- R3: A packet that reaches 16 bytes without `in_last` closes on its 16th byte. The next byte starts a new packet.
- R4: `cts` is low from the clock edge where the third completed entry is recorded. It stays low while three or more entries are complete.
- R5: `cts` is high whenever two or fewer entries are complete, including the edge where a release brings the count down to two.
- R6: With `cts` low and three entries complete, a full 16-byte packet is still accepted intact into the fourth entry.
- R7: A byte that arrives while four entries are complete is discarded. `overflow` then goes high and stays high until reset.
- R8: `rd_len` gives the byte count of the head packet while `rd_valid` is high.
- R9: `rd_valid` is high only when at least one completed packet is held. A packet that is still being filled never raises it.
- R10: A `rd_pop` pulse while `rd_valid` is low has no effect on the stored packets or on `cts`.
- R11: If a packet completes in the same cycle as a release, the number of completed entries and `cts` stay unchanged.
- R12: After reset, `cts` is 1, `rd_valid` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a packet |
| cts | output | 1 | Clear-to-send toward the sender |
| overflow | output | 1 | Sticky flag for a discarded byte |
| rd_valid | output | 1 | A completed packet is at the head |
| rd_len | output | 5 | Byte count of the head packet |
| rd_addr | input | 4 | Byte index into the head packet |
| rd_data | output | 8 | Byte of the head packet at `rd_addr` |
| rd_pop | input | 1 | Release the head packet |

## Verification
Two events can land on the same edge: a packet completing at the write side and the head entry being released. The bench provokes this by driving a packet's final byte while `rd_pop` is high, with three entries held and `cts` already low. The completed count and `cts` must stay as they were, and the closed packet must later read back with the right length and bytes. A second collision is a discarded byte arriving in the same cycle as a release from a full buffer. A behavioural queue model in the bench judges both cases on every clock.

// File: rtl/pkt_fifo_cts.sv
module pkt_fifo_cts #(
  parameter int DATA_W    = 8,
  parameter int MAX_LEN   = 16,
  parameter int ENTRIES   = 4,
  parameter int STOP_AT   = 3,
  parameter int RESUME_AT = 2,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int IDX_W = $clog2(MAX_LEN),
  localparam int PTR_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              cts,
  output logic              overflow,
  output logic              rd_valid,
  output logic [LEN_W-1:0]  rd_len,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_pop
);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] STOP   = CNT_W'(STOP_AT);
  localparam logic [CNT_W-1:0] RESUME = CNT_W'(RESUME_AT);
  localparam logic [IDX_W-1:0] LASTI  = IDX_W'(MAX_LEN - 1);
  localparam logic [PTR_W-1:0] LASTP  = PTR_W'(ENTRIES - 1);

  logic [DATA_W-1:0] mem   [ENTRIES][MAX_LEN];
  logic [LEN_W-1:0]  len_q [ENTRIES];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [IDX_W-1:0]  fill;
  logic [CNT_W-1:0]  occ, occ_nx;
  logic              accept, closing, popping;

  assign accept  = in_valid && (occ < FULL);
  assign closing = accept && (in_last || fill == LASTI);
  assign popping = rd_pop && (occ != '0);
  assign occ_nx  = occ + CNT_W'(closing) - CNT_W'(popping);

  assign rd_valid = (occ != '0);
  assign rd_len   = len_q[rd_ptr];
  assign rd_data  = mem[rd_ptr][rd_addr];

  always_ff @(posedge clk)
    if (accept) mem[wr_ptr][fill] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      occ      <= '0;
      cts      <= 1'b1;
      overflow <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) len_q[i] <= '0;
    end else begin
      occ <= occ_nx;
      if (in_valid && !accept) overflow <= 1'b1;
      if (closing) begin
        len_q[wr_ptr] <= LEN_W'(fill) + LEN_W'(1);
        wr_ptr        <= (wr_ptr == LASTP) ? '0 : wr_ptr + PTR_W'(1);
        fill          <= '0;
      end else if (accept) begin
        fill <= fill + IDX_W'(1);
      end
      if (popping) rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + PTR_W'(1);
      if (occ_nx >= STOP)        cts <= 1'b0;
      else if (occ_nx <= RESUME) cts <= 1'b1;
    end
  end
endmodule

module pkt_fifo_cts_chk #(
  parameter int MAX_LEN   = 16,
  parameter int ENTRIES   = 4,
  parameter int STOP_AT   = 3,
  parameter int RESUME_AT = 2,
  parameter int LEN_W     = 5,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             rd_pop,
  input logic             cts,
  input logic             overflow,
  input logic             rd_valid,
  input logic [LEN_W-1:0] rd_len,
  input logic [CNT_W-1:0] occ
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ENTRIES);

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_len != '0 && rd_len <= LEN_W'(MAX_LEN))); // R8
  AST_CTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= CNT_W'(STOP_AT)) |-> !cts); // R4
  AST_CTS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (occ <= CNT_W'(RESUME_AT)) |-> cts); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(in_valid) && $past(occ) == FULL)); // R7
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !in_valid) |=> !rd_valid); // R9
  AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_valid && in_valid && in_last && occ < FULL) |=> $stable(occ)); // R11
endmodule

bind pkt_fifo_cts pkt_fifo_cts_chk #(
  .MAX_LEN(MAX_LEN), .ENTRIES(ENTRIES), .STOP_AT(STOP_AT),
  .RESUME_AT(RESUME_AT), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .rd_pop(rd_pop), .cts(cts), .overflow(overflow), .rd_valid(rd_valid),
  .rd_len(rd_len), .occ(occ)
);

// File: tb/pkt_fifo_cts_tb.sv
module pkt_fifo_cts_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, rd_pop = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] rd_addr = '0;
  logic       cts, overflow, rd_valid;
  logic [4:0] rd_len;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  logic [127:0] q_pkt[$];
  int           q_len[$];
  logic [127:0] cur = '0;
  int           cur_n = 0;
  logic         m_ovf = 1'b0;
  logic         done = 1'b0;

  always #10 clk = ~clk;

  pkt_fifo_cts u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .cts(cts), .overflow(overflow), .rd_valid(rd_valid),
    .rd_len(rd_len), .rd_addr(rd_addr), .rd_data(rd_data), .rd_pop(rd_pop)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model();
    bit acc, pop;
    acc = in_valid && (q_pkt.size() < 4);
    pop = rd_pop && (q_pkt.size() > 0);
    if (in_valid && !acc) m_ovf = 1'b1;
    if (pop) begin
      void'(q_pkt.pop_front());
      void'(q_len.pop_front());
    end
    if (acc) begin
      cur[cur_n*8 +: 8] = in_data;
      cur_n++;
      if (in_last || cur_n == 16) begin
        q_pkt.push_back(cur);
        q_len.push_back(cur_n);
        cur = '0;
        cur_n = 0;
      end
    end
  endtask

  task automatic compare();
    logic [127:0] p;
    int n;
    n = q_pkt.size();
    chk(cts == (n < 3), (n >= 3) ? "R4 cts" : "R5 cts", cts, n < 3);
    chk(rd_valid == (n > 0), "R9 rd_valid", rd_valid, n > 0);
    chk(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
    if (n > 0) begin
      chk(rd_len == q_len[0], "R8 rd_len", rd_len, q_len[0]);
      if (int'(rd_addr) < q_len[0]) begin
        p = q_pkt[0];
        chk(rd_data == p[rd_addr*8 +: 8], "R1 rd_data", rd_data, p[rd_addr*8 +: 8]);
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input int n, input int base, input bit with_last);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(base + i);
      in_last  = with_last && (i == n - 1);
      cyc();
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic read_head();
    int n;
    n = q_len[0];
    for (int a = 0; a < n; a++) begin
      rd_addr = 4'(a);
      cyc();
    end
    rd_pop = 1'b1;
    cyc();
    rd_pop = 1'b0;
    rd_addr = '0;
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog act=%0d exp=done", cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cts == 1'b1, "R12 cts", cts, 1);
    chk(rd_valid == 1'b0, "R12 rd_valid", rd_valid, 0);
    chk(overflow == 1'b0, "R12 overflow", overflow, 0);

    send(1, 8'hA0, 1'b1);
    chk(rd_len == 5'd1, "R2 single", rd_len, 1);
    read_head();

    send(3, 8'h10, 1'b0);
    chk(rd_valid == 1'b0, "R9 partial", rd_valid, 0);
    send(2, 8'h13, 1'b1);
    chk(rd_len == 5'd5, "R2 five", rd_len, 5);
    read_head();

    send(16, 8'h40, 1'b0);
    chk(rd_valid && rd_len == 5'd16, "R3 auto close", rd_len, 16);
    send(1, 8'h77, 1'b0);
    send(1, 8'h78, 1'b1);
    read_head();
    chk(rd_len == 5'd2, "R3 next packet", rd_len, 2);
    read_head();

    rd_pop = 1'b1;
    cyc();
    rd_pop = 1'b0;
    chk(!rd_valid && cts, "R10 empty pop", rd_valid, 0);
    send(3, 8'h90, 1'b1);
    chk(rd_len == 5'd3, "R10 after pop", rd_len, 3);
    read_head();

    send(4, 8'h20, 1'b1);
    send(7, 8'h30, 1'b1);
    chk(cts == 1'b1, "R5 two held", cts, 1);
    send(2, 8'h50, 1'b1);
    chk(cts == 1'b0, "R4 three held", cts, 0);
    send(16, 8'hC0, 1'b0);
    chk(q_pkt.size() == 4 && rd_valid, "R6 in flight", q_pkt.size(), 4);
    send(1, 8'hEE, 1'b1);
    chk(overflow == 1'b1, "R7 drop", overflow, 1);
    chk(rd_len == 5'd4, "R7 head kept", rd_len, 4);

    rd_pop = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hEF;
    in_last = 1'b1;
    cyc();
    rd_pop = 1'b0;
    in_valid = 1'b0;
    in_last = 1'b0;
    chk(rd_len == 5'd7 && !cts, "R7 drop with pop", rd_len, 7);

    send(2, 8'h60, 1'b0);
    rd_pop = 1'b1;
    send(1, 8'h62, 1'b1);
    rd_pop = 1'b0;
    chk(q_pkt.size() == 3 && cts == 1'b0, "R11 swap", cts, 0);
    chk(rd_len == 5'd2, "R11 head", rd_len, 2);

    read_head();
    chk(cts == 1'b1, "R5 resume", cts, 1);
    read_head();
    chk(rd_len == 5'd3, "R6 R11 tail len", rd_len, 3);
    read_head();
    chk(rd_valid == 1'b0, "R9 drained", rd_valid, 0);
    chk(overflow == 1'b1, "R7 sticky", overflow, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule